// File: doc/BRIEF.md
# Instruction Address Unit with Return Stack

This block produces the fetch address for a small 8-bit controller core whose instruction words are 14 bits wide. It keeps a 13-bit program counter and a circular stack of eight return addresses. Each instruction cycle, the decoder raises `step` together with at most one command, or with several when an interrupt overlaps an instruction. The unit then advances, jumps, calls, returns or vectors to the interrupt handler.

Only the lowest 2K words of the 8K logical space are built, so the fetch address is the low 11 bits of the counter, and any higher address folds onto the implemented words. A return that carries a literal also hands that literal to the working register through a one-cycle write strobe. Entering and leaving an interrupt clears and sets a global interrupt enable flag.

Top module: `pc_unit`

## Requirements
- R1: A cycle with `rst_n` low at a rising edge sets the counter to 0000h, clears `gie` and empties the stack; a return right after reset yields address 0000h.
- R2: With `step` high and no command, the counter rises by one, and 1FFFh is followed by 0000h.
- R3: `fetch_addr` always equals the low 11 bits of `pc_out`, so addresses 0800h and above fold onto the 2K implemented words.
- R4: A jump loads the counter with `{page_sel, target}` (page bits on top, bits 12:11) and leaves the stack unchanged.
- R5: A call pushes the counter plus one (modulo 2^13) and then loads `{page_sel, target}`.
- R6: A plain return loads the counter with the most recently pushed address that has not yet been removed.
- R7: A taken interrupt pushes the counter plus one, loads 0004h and clears `gie`.
- R8: A return from interrupt pops the stack into the counter and sets `gie`.
- R9: A return with literal pops the stack into the counter, and in the same cycle it drives `w_we` high with `w_data` equal to `lit_in`. In every other cycle `w_we` is low and `w_data` is zero.
- R10: The stack is a ring of eight slots. A ninth push overwrites the oldest entry with no error, and a pop from an empty ring wraps to the top slot, so nine pushes of A1..A9 pop back as A9, A8, ..., A2, A9.
- R11: With `step` low, the counter, `gie` and the stack hold, and `w_we` stays low, whatever commands are present.
- R12: When several commands share a cycle, only one acts, in this order of precedence: interrupt, call, jump, return from interrupt, return, return with literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Instruction cycle enable |
| irq_take | input | 1 | Enter the interrupt handler |
| do_call | input | 1 | Subroutine call |
| do_jump | input | 1 | Unconditional jump |
| do_retfie | input | 1 | Return from interrupt |
| do_ret | input | 1 | Plain return |
| do_retlw | input | 1 | Return with literal |
| target | input | 11 | Jump or call target within a page |
| page_sel | input | 2 | Upper counter bits for jump and call |
| lit_in | input | 8 | Literal for return with literal |
| fetch_addr | output | 11 | Address into the implemented program memory |
| pc_out | output | 13 | Full program counter |
| gie | output | 1 | Global interrupt enable |
| w_we | output | 1 | Working register write strobe |
| w_data | output | 8 | Working register write data |

## Verification
A corrupted stack slot or pointer stays hidden until a pop, and then it shows at `pc_out` and `fetch_addr` on the edge that performs that return. Nested calls eight deep, overflowing pushes and pops past empty therefore bring stale state out to the ports. A wrong precedence decision or a wrong counter value shows at the very next edge. A bad `gie` shows at the edge after an interrupt entry or exit, and a bad literal strobe shows in the same cycle as the command. Because the bench compares every cycle against its own model, the first divergence is reported in the cycle it happens.

// File: rtl/pcu_pkg.sv
// Package for the instruction address unit: the operation chosen
// for each instruction cycle. Assumes a single command wins per cycle.
package pcu_pkg;
    typedef enum logic [2:0] {
        OP_HOLD, OP_INC, OP_JUMP, OP_CALL,
        OP_RET, OP_RETFIE, OP_RETLW, OP_IRQ
    } pc_op_e;
endpackage

// File: rtl/pcu_ctrl.sv
// Picks the operation for the cycle using fixed precedence and forms the
// next counter value and the stack controls. Purely combinational.
// Assumes pop_data is the stack top, valid in the same cycle.
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int IMPL_W  = 11,
    parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
    input  logic                   step,
    input  logic                   irq_take,
    input  logic                   do_call,
    input  logic                   do_jump,
    input  logic                   do_retfie,
    input  logic                   do_ret,
    input  logic                   do_retlw,
    input  logic [IMPL_W-1:0]      target,
    input  logic [PC_W-IMPL_W-1:0] page_sel,
    input  logic [PC_W-1:0]        pc_q,
    input  logic [PC_W-1:0]        pop_data,
    output pc_op_e                 op,
    output logic [PC_W-1:0]        pc_d,
    output logic                   push,
    output logic                   pop,
    output logic [PC_W-1:0]        push_data
);
    logic [PC_W-1:0] pc_inc;
    assign pc_inc = pc_q + PC_W'(1);

    // Precedence: interrupt, call, jump, retfie, ret, retlw, advance.
    always_comb begin
        if (!step)          op = OP_HOLD;
        else if (irq_take)  op = OP_IRQ;
        else if (do_call)   op = OP_CALL;
        else if (do_jump)   op = OP_JUMP;
        else if (do_retfie) op = OP_RETFIE;
        else if (do_ret)    op = OP_RET;
        else if (do_retlw)  op = OP_RETLW;
        else                op = OP_INC;
    end

    // Next counter value and stack requests for the chosen operation.
    always_comb begin
        pc_d      = pc_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_inc;
        unique case (op)
            OP_HOLD:  pc_d = pc_q;
            OP_INC:   pc_d = pc_inc;
            OP_JUMP:  pc_d = {page_sel, target};
            OP_CALL: begin
                pc_d = {page_sel, target};
                push = 1'b1;
            end
            OP_IRQ: begin
                pc_d = IRQ_VEC;
                push = 1'b1;
            end
            OP_RET, OP_RETFIE, OP_RETLW: begin
                pc_d = pop_data;
                pop  = 1'b1;
            end
            default:  pc_d = pc_q;
        endcase
    end
endmodule

// File: rtl/pcu_stack.sv
// Circular return-address stack. The pointer marks the next free slot;
// a push past DEPTH overwrites the oldest slot and a pop past empty wraps.
// Assumes push and pop never arrive in the same cycle.
module pcu_stack #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_dec  = ptr_q - PTR_W'(1);
    assign top_data = slot_q[ptr_dec];

    // Slot storage: clear on reset, write the free slot on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[ptr_q] <= push_data;
        end
    end

    // Pointer: wraps modulo DEPTH in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (push) ptr_q <= ptr_q + PTR_W'(1);
        else if (pop)  ptr_q <= ptr_dec;
    end

    // R10: a push advances the ring pointer by exactly one, wrapping freely.
    assert_push_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ptr_q == $past(ptr_q) + PTR_W'(1));

    // R10: a pop moves the pointer back by one, wrapping freely.
    assert_pop_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> ptr_q == $past(ptr_q) - PTR_W'(1));
endmodule

// File: rtl/pc_unit.sv
// Instruction address unit: program counter, return stack, interrupt
// enable and literal write strobe. Reset is synchronous and active low.
// Assumes the decoder qualifies every command with step.
module pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int IMPL_W = 11,
    parameter int DEPTH  = 8,
    parameter int LIT_W  = 8,
    parameter logic [PC_W-1:0] RESET_VEC = 13'h0000,
    parameter logic [PC_W-1:0] IRQ_VEC   = 13'h0004
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic                   irq_take,
    input  logic                   do_call,
    input  logic                   do_jump,
    input  logic                   do_retfie,
    input  logic                   do_ret,
    input  logic                   do_retlw,
    input  logic [IMPL_W-1:0]      target,
    input  logic [PC_W-IMPL_W-1:0] page_sel,
    input  logic [LIT_W-1:0]       lit_in,
    output logic [IMPL_W-1:0]      fetch_addr,
    output logic [PC_W-1:0]        pc_out,
    output logic                   gie,
    output logic                   w_we,
    output logic [LIT_W-1:0]       w_data
);
    pc_op_e          op;
    logic [PC_W-1:0] pc_q, pc_d, push_data, top_data;
    logic            push, pop, gie_q;

    pcu_ctrl #(.PC_W(PC_W), .IMPL_W(IMPL_W), .IRQ_VEC(IRQ_VEC)) u_ctrl (
        .step(step), .irq_take(irq_take), .do_call(do_call),
        .do_jump(do_jump), .do_retfie(do_retfie), .do_ret(do_ret),
        .do_retlw(do_retlw), .target(target), .page_sel(page_sel),
        .pc_q(pc_q), .pop_data(top_data), .op(op), .pc_d(pc_d),
        .push(push), .pop(pop), .push_data(push_data)
    );

    pcu_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(push_data), .top_data(top_data)
    );

    // Counter register: vector on reset, otherwise the chosen next value.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= pc_d;
    end

    // Interrupt enable: cleared on entry, set on return from interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)               gie_q <= 1'b0;
        else if (op == OP_IRQ)    gie_q <= 1'b0;
        else if (op == OP_RETFIE) gie_q <= 1'b1;
    end

    // Fetch address folds onto the implemented words; literal strobe.
    always_comb begin
        fetch_addr = pc_q[IMPL_W-1:0];
        pc_out     = pc_q;
        gie        = gie_q;
        w_we       = (op == OP_RETLW);
        w_data     = (op == OP_RETLW) ? lit_in : '0;
    end

    // R2: an uncommanded step advances the counter by one, wrapping.
    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !irq_take && !do_call && !do_jump && !do_retfie && !do_ret && !do_retlw)
        |=> pc_out == $past(pc_out) + PC_W'(1));

    // R7: interrupt entry vectors and clears the enable.
    assert_irq_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && irq_take) |=> (pc_out == IRQ_VEC) && !gie);

    // R8: return from interrupt, when it wins, sets the enable.
    assert_retfie_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && do_retfie && !irq_take && !do_call && !do_jump) |=> gie);

    // R11: without step, counter and enable hold.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc_out) && $stable(gie));

    // R9: the literal strobe only appears in a stepped cycle.
    assert_strobe_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_we |-> step && do_retlw);
endmodule

// File: tb/tb_pc_unit.sv
// Self-checking bench: directed corners plus seeded random commands,
// compared every cycle with a bench model built from the requirements.
module tb_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, irq_take = 1'b0, do_call = 1'b0, do_jump = 1'b0;
    logic        do_retfie = 1'b0, do_ret = 1'b0, do_retlw = 1'b0;
    logic [10:0] target = '0;
    logic [1:0]  page_sel = '0;
    logic [7:0]  lit_in = '0;
    logic [10:0] fetch_addr;
    logic [12:0] pc_out;
    logic        gie, w_we;
    logic [7:0]  w_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model state.
    logic [12:0] m_pc;
    logic        m_gie;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;

    always #4 clk = ~clk;

    pc_unit dut (
        .clk(clk), .rst_n(rst_n), .step(step), .irq_take(irq_take),
        .do_call(do_call), .do_jump(do_jump), .do_retfie(do_retfie),
        .do_ret(do_ret), .do_retlw(do_retlw), .target(target),
        .page_sel(page_sel), .lit_in(lit_in), .fetch_addr(fetch_addr),
        .pc_out(pc_out), .gie(gie), .w_we(w_we), .w_data(w_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_gie = 1'b0; m_sp = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    // Model push and pop on the ring of eight (R10).
    function automatic logic [12:0] m_pop();
        m_sp = m_sp - 3'd1;
        return m_stk[m_sp];
    endfunction

    task automatic m_push(input logic [12:0] v);
        m_stk[m_sp] = v;
        m_sp = m_sp + 3'd1;
    endtask

    // Registered outputs, sampled at the falling edge (R1..R8, R3).
    task automatic check_state(input string req);
        check({req, " pc"}, 32'(pc_out), 32'(m_pc));
        check("R3 fetch", 32'(fetch_addr), 32'(m_pc[10:0]));
        check({req, " gie"}, 32'(gie), 32'(m_gie));
    endtask

    // Drive one cycle at a falling edge, check the strobe, update the model,
    // then check registered state at the next falling edge.
    task automatic cyc(input string req, input logic s, input logic i,
                       input logic c, input logic j, input logic rf,
                       input logic r, input logic rl, input logic [1:0] pg,
                       input logic [10:0] t, input logic [7:0] l);
        logic wexp;
        step = s; irq_take = i; do_call = c; do_jump = j;
        do_retfie = rf; do_ret = r; do_retlw = rl;
        page_sel = pg; target = t; lit_in = l;
        #1;
        wexp = s && rl && !i && !c && !j && !rf && !r;
        check("R9 w_we", 32'(w_we), 32'(wexp));
        check("R9 w_data", 32'(w_data), wexp ? 32'(l) : 32'd0);
        // R12 precedence in the model.
        if (s) begin
            if (i) begin
                m_push(m_pc + 13'd1); m_pc = 13'h0004; m_gie = 1'b0;
            end else if (c) begin
                m_push(m_pc + 13'd1); m_pc = {pg, t};
            end else if (j) begin
                m_pc = {pg, t};
            end else if (rf) begin
                m_pc = m_pop(); m_gie = 1'b1;
            end else if (r || rl) begin
                m_pc = m_pop();
            end else begin
                m_pc = m_pc + 13'd1;
            end
        end
        @(negedge clk);
        check_state(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset with commands present still leaves the reset state.
        step = 1'b1; do_jump = 1'b1; target = 11'h123;
        @(negedge clk);
        rst_n = 1'b1; step = 1'b0; do_jump = 1'b0;
        #1;
        check("R1 pc", 32'(pc_out), 32'd0);
        check("R1 gie", 32'(gie), 32'd0);
        // R1: return after reset yields 0000h.
        cyc("R1", 1, 0, 0, 0, 0, 1, 0, 2'd0, 11'd0, 8'd0);
        // R2: plain advance.
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 2'd0, 11'd0, 8'd0);
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 2'd0, 11'd0, 8'd0);
        // R4, R3: jump to 1FFFh; fetch folds to 7FFh; R2 wrap to 0000h.
        cyc("R4", 1, 0, 0, 1, 0, 0, 0, 2'd3, 11'h7FF, 8'd0);
        check("R3 fold", 32'(fetch_addr), 32'h7FF);
        cyc("R2 wrap", 1, 0, 0, 0, 0, 0, 0, 2'd0, 11'd0, 8'd0);
        check("R2 wrap", 32'(pc_out), 32'd0);
        // R11: step low with every command present holds everything.
        cyc("R11", 0, 1, 1, 1, 1, 1, 1, 2'd1, 11'h055, 8'hAA);
        // R10: nine calls, then nine returns.
        for (int k = 0; k < 9; k++)
            cyc("R5 R10", 1, 0, 1, 0, 0, 0, 0, 2'd0, 11'(16 * k + 3), 8'd0);
        for (int k = 0; k < 9; k++)
            cyc("R6 R10", 1, 0, 0, 0, 0, 1, 0, 2'd0, 11'd0, 8'd0);
        // R7, R8: interrupt entry then return from interrupt.
        cyc("R7", 1, 1, 0, 0, 0, 0, 0, 2'd0, 11'd0, 8'd0);
        check("R7 vec", 32'(pc_out), 32'h4);
        cyc("R8", 1, 0, 0, 0, 1, 0, 0, 2'd0, 11'd0, 8'd0);
        check("R8 gie", 32'(gie), 32'd1);
        // R9: call, then return with literal.
        cyc("R5", 1, 0, 1, 0, 0, 0, 0, 2'd2, 11'h321, 8'd0);
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 2'd0, 11'd0, 8'h5C);
        // R12: all commands at once: interrupt wins; then call over jump.
        cyc("R12", 1, 1, 1, 1, 1, 1, 1, 2'd1, 11'h0AA, 8'h11);
        cyc("R12", 1, 0, 1, 1, 1, 1, 1, 2'd1, 11'h0AA, 8'h11);
        cyc("R12", 1, 0, 0, 1, 1, 1, 1, 2'd2, 11'h0BB, 8'h22);
        cyc("R12", 1, 0, 0, 0, 1, 1, 1, 2'd0, 11'd0, 8'h33);
        // Random mix of commands.
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] r8;
            r8 = 8'($urandom);
            cyc("RND", ($urandom % 8) != 0, ($urandom % 12) == 0,
                ($urandom % 6) == 0, ($urandom % 8) == 0,
                ($urandom % 12) == 0, ($urandom % 6) == 0,
                ($urandom % 8) == 0, 2'($urandom), 11'($urandom), r8);
        end
        // R1: reset again mid-run, then check state and empty stack.
        rst_n = 1'b0; step = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check_state("R1");
        cyc("R1", 1, 0, 0, 0, 0, 1, 0, 2'd0, 11'd0, 8'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule